// File: doc/BRIEF.md
# Two-Level Latched Interrupt Aggregator

This block collects level-sensitive serial interrupt lines and single-cycle error events into a first-level status register. Every source that is seen high sets its status bit, and that bit then holds until software writes a one to it. The first level masks the status bits and gates the result with an enable bit. The outcome is a single forwarded line.

The forwarded line appears as one bit of a read-only input register in a second level. The second level keeps its own sticky status, which accumulates the input AND its mask. The block's single interrupt output is high whenever that second-level status is nonzero. A polarity register exists in the second level and can be read and written, but it changes nothing.

Software reaches both levels through one 32-bit register port that uses an 8-bit byte offset. A write is accepted on every clock cycle, so the port applies no back-pressure. A read returns data combinationally for the offset on the read address. All state is registered. A source that goes high therefore shows in the first-level status one cycle later, and reaches the interrupt output one cycle after that.

Top module: `irq_cascade_top`

## Requirements
- R1: After reset every register reads zero and `irq_out` is low.
- R2: A high level on serial input n sets first-level status (offset 0x38) bit 31−n at the next clock edge, for n from 0 to 16. A low level never clears that bit.
- R3: Error event input bit 8 sets status bit 10, and error event input bits 7..0 set status bits 7..0.
- R4: Writing to 0x38 clears each status bit whose data bit is 1. A source that is high in the same cycle wins over the clear of its bit.
- R5: Second-level input register 0x5C reads bit 11 as (control 0x30 bit 31) AND ((status AND mask 0x34) ≠ 0). All its other bits read 0, and writes to 0x5C are ignored.
- R6: Second-level status 0x50 ORs in (input AND mask 0x54) at every clock edge and keeps it. Writing a 1 to a bit of 0x50 clears it, but the same-cycle latch wins.
- R7: `irq_out` is high exactly when second-level status is nonzero.
- R8: Polarity register 0x58 reads back the value written to it and has no effect on status or on `irq_out`.
- R9: Control 0x30, first-level mask 0x34 and second-level mask 0x54 read back the full 32-bit value written to them.
- R10: A read of any offset other than 0x30, 0x34, 0x38, 0x50, 0x54, 0x58 or 0x5C returns 0xFFFFFFFF. A write to such an offset changes no register.
- R11: First-level status bits 14..11, 9 and 8 have no source and always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_irq_in | input | NUM_SER | Serial interrupt levels, sampled every cycle |
| err_evt_in | input | NUM_ERR | Error event pulses, sampled every cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| irq_out | output | 1 | Aggregated interrupt |

## Verification
The hardest case to reach is a collision: a source is high in the very cycle that software clears the bit it sets. This can happen in either level. The bench drives the input change and the write strobe on the same falling edge, so both land on the same rising edge. It then reads back to confirm that the latch won. It also clears the second level while the first level is still forwarding, then drops the first level and confirms that the second-level bit stays set until a later clear.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 8;
  localparam int EN_BIT   = 31;
  localparam int FWD_BIT  = 11;
  localparam int ERR_SPLIT = 8;
  localparam int ERR_HIGH_BASE = 10;

  localparam logic [ADDR_W-1:0] OFF_L1_CTRL = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_L1_MASK = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_L1_STAT = 8'h38;
  localparam logic [ADDR_W-1:0] OFF_L2_STAT = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_L2_MASK = 8'h54;
  localparam logic [ADDR_W-1:0] OFF_L2_POL  = 8'h58;
  localparam logic [ADDR_W-1:0] OFF_L2_IN   = 8'h5C;

  // Error event i lands at bit i below the split, at ERR_HIGH_BASE upward beyond it
  function automatic int err_pos(input int i);
    return (i < ERR_SPLIT) ? i : ERR_HIGH_BASE + (i - ERR_SPLIT);
  endfunction

  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    return (a == OFF_L1_CTRL) || (a == OFF_L1_MASK) || (a == OFF_L1_STAT) ||
           (a == OFF_L2_STAT) || (a == OFF_L2_MASK) || (a == OFF_L2_POL)  ||
           (a == OFF_L2_IN);
  endfunction
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_cascade_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [REG_W-1:0]  l1_ctrl,
  input  logic [REG_W-1:0]  l1_mask,
  input  logic [REG_W-1:0]  l1_stat,
  input  logic [REG_W-1:0]  l2_stat,
  input  logic [REG_W-1:0]  l2_mask,
  input  logic [REG_W-1:0]  l2_pol,
  input  logic [REG_W-1:0]  l2_in,
  output logic              we_l1_ctrl,
  output logic              we_l1_mask,
  output logic              we_l1_clr,
  output logic              we_l2_clr,
  output logic              we_l2_mask,
  output logic              we_l2_pol,
  output logic [REG_W-1:0]  rd_data
);
  always_comb begin
    we_l1_ctrl = wr_en && (wr_addr == OFF_L1_CTRL);
    we_l1_mask = wr_en && (wr_addr == OFF_L1_MASK);
    we_l1_clr  = wr_en && (wr_addr == OFF_L1_STAT);
    we_l2_clr  = wr_en && (wr_addr == OFF_L2_STAT);
    we_l2_mask = wr_en && (wr_addr == OFF_L2_MASK);
    we_l2_pol  = wr_en && (wr_addr == OFF_L2_POL);
  end

  always_comb begin
    case (rd_addr)
      OFF_L1_CTRL: rd_data = l1_ctrl;
      OFF_L1_MASK: rd_data = l1_mask;
      OFF_L1_STAT: rd_data = l1_stat;
      OFF_L2_STAT: rd_data = l2_stat;
      OFF_L2_MASK: rd_data = l2_mask;
      OFF_L2_POL:  rd_data = l2_pol;
      OFF_L2_IN:   rd_data = l2_in;
      default:     rd_data = '1;
    endcase
  end
endmodule

// File: rtl/irq_l1_stage.sv
module irq_l1_stage
  import irq_cascade_pkg::*;
#(
  parameter int NUM_SER = 17,
  parameter int NUM_ERR = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SER-1:0] ser_in,
  input  logic [NUM_ERR-1:0] err_in,
  input  logic               we_ctrl,
  input  logic               we_mask,
  input  logic               we_clr,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   ctrl_q,
  output logic [REG_W-1:0]   mask_q,
  output logic [REG_W-1:0]   stat_q,
  output logic               fwd
);
  logic [REG_W-1:0] ser_set;
  logic [REG_W-1:0] err_set;
  logic [REG_W-1:0] clr_vec;

  // Serial input n maps to status bit (REG_W-1-n)
  generate
    for (genvar b = 0; b < REG_W; b++) begin : g_ser_map
      if (b >= REG_W - NUM_SER) begin : g_src
        assign ser_set[b] = ser_in[REG_W-1-b];
      end else begin : g_nosrc
        assign ser_set[b] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    err_set = '0;
    for (int i = 0; i < NUM_ERR; i++) begin
      err_set[err_pos(i)] = err_set[err_pos(i)] | err_in[i];
    end
  end

  assign clr_vec = we_clr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (we_ctrl) ctrl_q <= wdata;
      if (we_mask) mask_q <= wdata;
      // A fresh source assertion outranks a software clear of the same bit
      stat_q <= (stat_q & ~clr_vec) | ser_set | err_set;
    end
  end

  assign fwd = ctrl_q[EN_BIT] && ((stat_q & mask_q) != '0);
endmodule

// File: rtl/irq_l2_stage.sv
module irq_l2_stage
  import irq_cascade_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fwd,
  input  logic             we_clr,
  input  logic             we_mask,
  input  logic             we_pol,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] in_vec,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] pol_q,
  output logic [REG_W-1:0] stat_q,
  output logic             irq
);
  logic [REG_W-1:0] clr_vec;

  always_comb begin
    in_vec = '0;
    in_vec[FWD_BIT] = fwd;
  end

  assign clr_vec = we_clr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      pol_q  <= '0;
      stat_q <= '0;
    end else begin
      if (we_mask) mask_q <= wdata;
      if (we_pol)  pol_q  <= wdata;
      stat_q <= (stat_q & ~clr_vec) | (in_vec & mask_q);
    end
  end

  assign irq = (stat_q != '0);
endmodule

// File: rtl/irq_cascade_top.sv
module irq_cascade_top
  import irq_cascade_pkg::*;
#(
  parameter int NUM_SER = 17,
  parameter int NUM_ERR = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SER-1:0] ser_irq_in,
  input  logic [NUM_ERR-1:0] err_evt_in,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [7:0]         rd_addr,
  output logic [31:0]        rd_data,
  output logic               irq_out
);
  logic [REG_W-1:0] l1_ctrl, l1_mask, l1_stat;
  logic [REG_W-1:0] l2_stat, l2_mask, l2_pol, l2_in;
  logic             fwd;
  logic we_l1_ctrl, we_l1_mask, we_l1_clr, we_l2_clr, we_l2_mask, we_l2_pol;

  irq_reg_decode u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .l1_ctrl(l1_ctrl), .l1_mask(l1_mask), .l1_stat(l1_stat),
    .l2_stat(l2_stat), .l2_mask(l2_mask), .l2_pol(l2_pol), .l2_in(l2_in),
    .we_l1_ctrl(we_l1_ctrl), .we_l1_mask(we_l1_mask), .we_l1_clr(we_l1_clr),
    .we_l2_clr(we_l2_clr), .we_l2_mask(we_l2_mask), .we_l2_pol(we_l2_pol),
    .rd_data(rd_data)
  );

  irq_l1_stage #(.NUM_SER(NUM_SER), .NUM_ERR(NUM_ERR)) u_l1 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_irq_in), .err_in(err_evt_in),
    .we_ctrl(we_l1_ctrl), .we_mask(we_l1_mask), .we_clr(we_l1_clr),
    .wdata(wr_data), .ctrl_q(l1_ctrl), .mask_q(l1_mask), .stat_q(l1_stat),
    .fwd(fwd)
  );

  irq_l2_stage u_l2 (
    .clk(clk), .rst_n(rst_n), .fwd(fwd),
    .we_clr(we_l2_clr), .we_mask(we_l2_mask), .we_pol(we_l2_pol),
    .wdata(wr_data), .in_vec(l2_in), .mask_q(l2_mask), .pol_q(l2_pol),
    .stat_q(l2_stat), .irq(irq_out)
  );
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
  import irq_cascade_pkg::*;
#(
  parameter int NUM_SER = 17
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [7:0]         wr_addr,
  input logic [NUM_SER-1:0] ser_irq_in,
  input logic [31:0]        l1_ctrl,
  input logic [31:0]        l1_mask,
  input logic [31:0]        l1_stat,
  input logic [31:0]        l2_mask,
  input logic [31:0]        l2_pol,
  input logic [31:0]        l2_stat,
  input logic               fwd,
  input logic               irq_out
);
  logic [31:0] ser_expect;
  always_comb begin
    ser_expect = '0;
    for (int i = 0; i < NUM_SER; i++) ser_expect[31-i] = ser_irq_in[i];
  end

  a_r2_ser_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_expect != 0) |=> ((l1_stat & $past(ser_expect)) == $past(ser_expect)));

  a_r4_l1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == OFF_L1_STAT) |=> ((l1_stat & $past(l1_stat)) == $past(l1_stat)));

  a_r6_l2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == OFF_L2_STAT) |=> ((l2_stat & $past(l2_stat)) == $past(l2_stat)));

  a_r5_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !l1_ctrl[EN_BIT] |-> !fwd);

  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(fwd && l2_mask[FWD_BIT]));

  a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_mapped(wr_addr)) |=>
      ($stable(l1_ctrl) && $stable(l1_mask) && $stable(l2_mask) && $stable(l2_pol)));
endmodule

bind irq_cascade_top irq_cascade_chk #(.NUM_SER(NUM_SER)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .ser_irq_in(ser_irq_in), .l1_ctrl(l1_ctrl), .l1_mask(l1_mask),
  .l1_stat(l1_stat), .l2_mask(l2_mask), .l2_pol(l2_pol), .l2_stat(l2_stat),
  .fwd(fwd), .irq_out(irq_out)
);

// File: tb/tb_irq_cascade_top.sv
`timescale 1ns/1ps
module tb_irq_cascade_top;
  localparam int NUM_SER = 17;
  localparam int NUM_ERR = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_SER-1:0] ser_irq_in = '0;
  logic [NUM_ERR-1:0] err_evt_in = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic irq_out;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_cascade_top #(.NUM_SER(NUM_SER), .NUM_ERR(NUM_ERR)) dut (
    .clk(clk), .rst_n(rst_n), .ser_irq_in(ser_irq_in), .err_evt_in(err_evt_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic clear_all();
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(20 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 ctrl", 8'h30, 32'h0);
    rd_chk("R1 mask1", 8'h34, 32'h0);
    rd_chk("R1 stat1", 8'h38, 32'h0);
    rd_chk("R1 stat2", 8'h50, 32'h0);
    rd_chk("R1 mask2", 8'h54, 32'h0);
    rd_chk("R1 pol", 8'h58, 32'h0);
    rd_chk("R1 in2", 8'h5C, 32'h0);
    check("R1 irq", {31'b0, irq_out}, 32'h0);

    // R9 readback
    wr(8'h30, 32'h8000_0003);
    rd_chk("R9 ctrl", 8'h30, 32'h8000_0003);
    wr(8'h34, 32'hA5A5_5A5A);
    rd_chk("R9 mask1", 8'h34, 32'hA5A5_5A5A);
    wr(8'h54, 32'h1234_5678);
    rd_chk("R9 mask2", 8'h54, 32'h1234_5678);

    // Sweep: every serial input under each enable/mask combination (R2 R5 R6 R7)
    for (int n = 0; n < NUM_SER; n++) begin
      for (int en = 0; en < 2; en++) begin
        for (int mb = 0; mb < 2; mb++) begin
          logic [31:0] bitv;
          logic pend;
          bitv = 32'h1 << (31 - n);
          pend = (en == 1) && (mb == 1);
          wr(8'h30, en ? 32'h8000_0000 : 32'h0);
          wr(8'h34, mb ? bitv : 32'h0);
          wr(8'h54, 32'h0000_0800);
          clear_all();
          ser_irq_in = NUM_SER'(1) << n;
          @(negedge clk);
          ser_irq_in = '0;
          rd_chk("R2 latch", 8'h38, bitv);
          @(negedge clk);
          rd_chk("R2 hold after low", 8'h38, bitv);
          rd_chk("R5 forward bit", 8'h5C, pend ? 32'h800 : 32'h0);
          rd_chk("R6 level2 latch", 8'h50, pend ? 32'h800 : 32'h0);
          check("R7 irq", {31'b0, irq_out}, {31'b0, pend});
        end
      end
    end

    // R3 / R11 error events and unsourced bits
    wr(8'h30, 32'h0);
    clear_all();
    err_evt_in = '1;
    @(negedge clk);
    err_evt_in = '0;
    rd_chk("R3 error bits", 8'h38, 32'h0000_04FF);
    ser_irq_in = '1;
    err_evt_in = '1;
    @(negedge clk);
    ser_irq_in = '0;
    err_evt_in = '0;
    rd_chk("R11 unsourced bits zero", 8'h38, 32'hFFFF_84FF);

    // R4 partial clear and latch-over-clear priority
    wr(8'h38, 32'h8000_0001);
    rd_chk("R4 partial clear", 8'h38, 32'h7FFF_84FE);
    wr(8'h38, 32'hFFFF_FFFF);
    rd_chk("R4 full clear", 8'h38, 32'h0);
    ser_irq_in = 17'h2;
    wr(8'h38, 32'h4000_0000);
    ser_irq_in = '0;
    rd_chk("R4 latch wins", 8'h38, 32'h4000_0000);
    wr(8'h38, 32'h4000_0000);
    rd_chk("R4 clear after source gone", 8'h38, 32'h0);

    // R6 level-2 mask off: input visible, status stays clear
    wr(8'h30, 32'h8000_0000);
    wr(8'h34, 32'h8000_0000);
    wr(8'h54, 32'h0);
    ser_irq_in = 17'h1;
    @(negedge clk);
    ser_irq_in = '0;
    @(negedge clk);
    rd_chk("R5 input with mask2 off", 8'h5C, 32'h800);
    rd_chk("R6 masked off", 8'h50, 32'h0);
    check("R7 irq low when stat2 zero", {31'b0, irq_out}, 32'h0);

    // R10 writes to input register ignored
    wr(8'h5C, 32'h0);
    rd_chk("R5 input write ignored", 8'h5C, 32'h800);

    // R6 level-2 latch vs clear, then stickiness
    wr(8'h54, 32'h800);
    @(negedge clk);
    rd_chk("R6 latched", 8'h50, 32'h800);
    wr(8'h50, 32'h800);
    rd_chk("R6 latch wins over clear", 8'h50, 32'h800);
    wr(8'h38, 32'hFFFF_FFFF);
    @(negedge clk);
    rd_chk("R6 sticky after source gone", 8'h50, 32'h800);
    check("R7 irq held", {31'b0, irq_out}, 32'h1);
    wr(8'h50, 32'h800);
    rd_chk("R6 cleared", 8'h50, 32'h0);
    check("R7 irq dropped", {31'b0, irq_out}, 32'h0);

    // R8 polarity stored but inert
    wr(8'h58, 32'hFFFF_FFFF);
    rd_chk("R8 pol readback", 8'h58, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R8 pol no irq", {31'b0, irq_out}, 32'h0);
    ser_irq_in = 17'h1;
    @(negedge clk);
    ser_irq_in = '0;
    @(negedge clk);
    check("R8 pol irq still active-high", {31'b0, irq_out}, 32'h1);

    // R10 unmapped offsets
    wr(8'h40, 32'h0000_1234);
    rd_chk("R10 unmapped read", 8'h40, 32'hFFFF_FFFF);
    rd_chk("R10 unmapped read 2", 8'h3C, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0);
    rd_chk("R10 ctrl kept", 8'h30, 32'h8000_0000);
    rd_chk("R10 mask1 kept", 8'h34, 32'h8000_0000);
    rd_chk("R10 mask2 kept", 8'h54, 32'h0000_0800);
    rd_chk("R10 pol kept", 8'h58, 32'hFFFF_FFFF);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule